// File: doc/BRIEF.md
# Cartridge Bank Mapper with Nametable Mirroring

This block sits between a CPU bus, a video bus and the memories of a banked cartridge, and turns their addresses into memory addresses. On the CPU side, the range from 0x6000 to 0xFFFF is split into five 8 KB windows. The lower four windows each take a bank byte. That byte either picks a 6-bit program ROM bank or lays 8 KB of work RAM over the window. Work RAM reads can be gated off by an enable flag in the same byte. The topmost window is fixed to the last ROM bank.

On the video side, the pattern area is cut into eight 1 KB slots, each with its own character bank. An access with video address bit 13 set goes to the internal nametable RAM instead. Its page bit comes from one of four mirroring modes.

All configuration goes through one indexed port. A write to 0x8000 picks a register index. A write to 0xA000 stores data into the register that index picks. Translation is combinational from the registered state, and a configuration write takes effect at the clock edge that samples it. The memories themselves are outside this block.

Top module: `cart_mapper`

## Requirements
- R1: After reset, the index, all eight character banks, all four program bank bytes and the mirror mode are 0. A read at 0x8000 to 0xDFFF therefore maps to ROM bank 0, every character slot maps to bank 0, and mirroring is vertical.
- R2: A CPU write to exactly 0x8000 loads bits 3:0 of the data into the register index; upper data bits are dropped. A CPU write to exactly 0xA000 stores the data into the register the index selects. The new value drives the outputs from the clock edge that samples the write strobe.
- R3: Index values 0 to 7 load character bank 0 to 7. `chr_addr` equals the bank of slot `ppu_addr[12:10]` concatenated with `ppu_addr[9:0]`.
- R4: Index values 8, 9, 10 and 11 load the bank bytes of the windows at 0x6000, 0x8000, 0xA000 and 0xC000. When bit 6 of the byte is clear, a read gives `prg_rom_addr` = {byte[5:0], `cpu_addr[12:0]`}, with `wram_sel`, `wram_en` and `open_bus` low.
- R5: The window at 0xE000 to 0xFFFF always maps to ROM bank 0x3F, whatever is stored in any register.
- R6: CPU reads below 0x6000 raise `open_bus` and keep `wram_sel` and `wram_en` low.
- R7: On a read through a window whose bank byte has bit 6 set, `wram_sel` is high and `wram_addr` = `cpu_addr[12:0]`. If bit 7 is also set, `wram_en` is high and `open_bus` is low. If bit 7 is clear, `wram_en` is low and `open_bus` is high.
- R8: A CPU write in 0x6000 to 0x7FFF raises `wram_sel` and `wram_en`, whatever the bank byte holds. A CPU write at 0x8000 or above, or below 0x6000, keeps `wram_en` low.
- R9: Index 12 loads the mirror mode from data bits 1:0. The page bit `ciram_addr[10]` is `ppu_addr[10]` in mode 0, `ppu_addr[11]` in mode 1, 0 in mode 2 and 1 in mode 3.
- R10: Writes to 0xA000 while the index is 13, 14 or 15 change no bank register and no mirror mode.
- R11: `ciram_sel` equals `ppu_addr[13]`, and `ciram_addr[9:0]` always equals `ppu_addr[9:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | High for a CPU write, low for a read |
| ppu_addr | input | 14 | Video bus address |
| prg_rom_addr | output | 19 | Program ROM byte address |
| wram_addr | output | 13 | Work RAM byte address |
| wram_sel | output | 1 | Access is aimed at work RAM |
| wram_en | output | 1 | Work RAM access is performed |
| open_bus | output | 1 | Read returns nothing (bus floats) |
| chr_addr | output | 18 | Character memory byte address |
| ciram_addr | output | 11 | Nametable RAM address |
| ciram_sel | output | 1 | Video access goes to nametable RAM |

## Verification
Assertions watch on every cycle that reads below 0x6000 float and that the top window stays on bank 0x3F. They also check that writes into the low window always reach work RAM, and that nametable offsets pass straight through. Two further checks run each cycle: an index write lands in the index register, and data written under the three unused indices leaves all bank state unchanged. The mapping of every register index to its slot or window, the RAM-enable gating per window and all four mirroring modes can only be shown by the bench. It programs each register through the port and compares the translated addresses with values worked out from the requirements.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;
    localparam int WIN_OFS_W  = 13;
    localparam int SLOT_OFS_W = 10;
    localparam int IDX_W      = 4;
    localparam int PRG_SLOTS  = 4;
    localparam int CHR_SLOTS  = 8;

    localparam logic [15:0] ADDR_SEL_PORT  = 16'h8000;
    localparam logic [15:0] ADDR_DATA_PORT = 16'hA000;

    localparam logic [IDX_W-1:0] IDX_PRG_BASE = 4'd8;
    localparam logic [IDX_W-1:0] IDX_MIRROR   = 4'd12;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_PAGE0 = 2'd2,
        MIR_PAGE1 = 2'd3
    } mirror_e;
endpackage

// File: rtl/cart_mapper_regs.sv
module cart_mapper_regs
    import cart_mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [15:0]                           cpu_addr,
    input  logic [7:0]                            cpu_wdata,
    input  logic                                  cpu_wr,
    output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank_o,
    output logic [PRG_SLOTS-1:0][7:0]             prg_byte_o,
    output mirror_e                               mirror_o
);
    typedef struct packed {
        logic [IDX_W-1:0]                     idx;
        logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr;
        logic [PRG_SLOTS-1:0][7:0]            prg;
        mirror_e                              mir;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic sel_hit, data_hit;

    always_comb begin
        sel_hit  = cpu_wr && (cpu_addr == ADDR_SEL_PORT);
        data_hit = cpu_wr && (cpu_addr == ADDR_DATA_PORT);
        cfg_d    = cfg_q;
        if (sel_hit) begin
            cfg_d.idx = cpu_wdata[IDX_W-1:0];
        end
        if (data_hit) begin
            if (cfg_q.idx < IDX_PRG_BASE) begin
                cfg_d.chr[cfg_q.idx[2:0]] = cpu_wdata[CHR_BANK_W-1:0];
            end else if (cfg_q.idx < IDX_MIRROR) begin
                cfg_d.prg[cfg_q.idx[1:0]] = cpu_wdata;
            end else if (cfg_q.idx == IDX_MIRROR) begin
                cfg_d.mir = mirror_e'(cpu_wdata[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign chr_bank_o = cfg_q.chr;
    assign prg_byte_o = cfg_q.prg;
    assign mirror_o   = cfg_q.mir;

    // R2: the index port captures the low nibble of the written byte
    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_SEL_PORT) |=> (cfg_q.idx == $past(cpu_wdata[IDX_W-1:0])));

    // R10: unused indices leave every bank and the mirror mode untouched
    p_unused_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_DATA_PORT && cfg_q.idx > IDX_MIRROR)
        |=> ($stable(chr_bank_o) && $stable(prg_byte_o) && $stable(mirror_o)));
endmodule

// File: rtl/cart_mapper_prg.sv
module cart_mapper_prg
    import cart_mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [15:0]                   cpu_addr,
    input  logic                          cpu_wr,
    input  logic [PRG_SLOTS-1:0][7:0]     prg_byte,
    output logic [PRG_BANK_W+WIN_OFS_W-1:0] rom_addr,
    output logic [WIN_OFS_W-1:0]          wram_addr,
    output logic                          wram_sel,
    output logic                          wram_en,
    output logic                          open_bus
);
    localparam logic [2:0] WIN_FIRST = 3'd3;
    localparam logic [2:0] WIN_FIXED = 3'd7;

    logic [2:0] win;
    logic [2:0] slot;
    logic [7:0] bank_byte;
    logic       below;
    logic       ram_pick;
    logic       ram_on;

    always_comb begin
        win       = cpu_addr[15:13];
        slot      = win - WIN_FIRST;
        below     = (win < WIN_FIRST);
        bank_byte = (win == WIN_FIXED) ? 8'(2**PRG_BANK_W - 1) : prg_byte[slot[1:0]];
        ram_pick  = bank_byte[6];
        ram_on    = bank_byte[7];

        rom_addr  = {bank_byte[PRG_BANK_W-1:0], cpu_addr[WIN_OFS_W-1:0]};
        wram_addr = cpu_addr[WIN_OFS_W-1:0];
        wram_sel  = 1'b0;
        wram_en   = 1'b0;
        open_bus  = 1'b0;

        if (below) begin
            open_bus = !cpu_wr;
        end else if (cpu_wr) begin
            wram_sel = (win == WIN_FIRST);
            wram_en  = (win == WIN_FIRST);
        end else begin
            wram_sel = ram_pick;
            wram_en  = ram_pick && ram_on;
            open_bus = ram_pick && !ram_on;
        end
    end

    // R6: reads below the first window float
    p_low_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr && cpu_addr < 16'h6000) |-> (open_bus && !wram_sel && !wram_en));

    // R5: the top window never leaves the last ROM bank
    p_top_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (&rom_addr[PRG_BANK_W+WIN_OFS_W-1:WIN_OFS_W] && !wram_sel));

    // R8: low-window writes always land in work RAM
    p_wram_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |-> (wram_sel && wram_en && !open_bus));

    // R7: an enabled RAM access never floats
    p_ram_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wram_en |-> (wram_sel && !open_bus));
endmodule

// File: rtl/cart_mapper_ppu.sv
module cart_mapper_ppu
    import cart_mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [13:0]                           ppu_addr,
    input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
    input  mirror_e                               mirror,
    output logic [CHR_BANK_W+SLOT_OFS_W-1:0]      chr_addr,
    output logic [SLOT_OFS_W:0]                   ciram_addr,
    output logic                                  ciram_sel
);
    logic [2:0] slot;
    logic       page;

    always_comb begin
        slot = ppu_addr[12:10];
        case (mirror)
            MIR_VERT:  page = ppu_addr[10];
            MIR_HORZ:  page = ppu_addr[11];
            MIR_PAGE0: page = 1'b0;
            default:   page = 1'b1;
        endcase
        chr_addr   = {chr_bank[slot], ppu_addr[SLOT_OFS_W-1:0]};
        ciram_addr = {page, ppu_addr[SLOT_OFS_W-1:0]};
        ciram_sel  = ppu_addr[13];
    end

    // R11: the nametable offset and the character offset agree
    p_offset_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ciram_addr[SLOT_OFS_W-1:0] == chr_addr[SLOT_OFS_W-1:0]);

    // R9: fixed-page modes ignore both page address bits
    p_fixed_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror == MIR_PAGE0 || mirror == MIR_PAGE1) |-> (ciram_addr[SLOT_OFS_W] == mirror[0]));
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8,
    localparam int PRG_AW    = PRG_BANK_W + WIN_OFS_W,
    localparam int CHR_AW    = CHR_BANK_W + SLOT_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [WIN_OFS_W-1:0] wram_addr,
    output logic              wram_sel,
    output logic              wram_en,
    output logic              open_bus,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [SLOT_OFS_W:0] ciram_addr,
    output logic              ciram_sel
);
    logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank;
    logic [PRG_SLOTS-1:0][7:0]            prg_byte;
    mirror_e                              mirror;

    cart_mapper_regs #(.CHR_BANK_W(CHR_BANK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_wr     (cpu_wr),
        .chr_bank_o (chr_bank),
        .prg_byte_o (prg_byte),
        .mirror_o   (mirror)
    );

    cart_mapper_prg #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .prg_byte  (prg_byte),
        .rom_addr  (prg_rom_addr),
        .wram_addr (wram_addr),
        .wram_sel  (wram_sel),
        .wram_en   (wram_en),
        .open_bus  (open_bus)
    );

    cart_mapper_ppu #(.CHR_BANK_W(CHR_BANK_W)) u_ppu (
        .clk        (clk),
        .rst_n      (rst_n),
        .ppu_addr   (ppu_addr),
        .chr_bank   (chr_bank),
        .mirror     (mirror),
        .chr_addr   (chr_addr),
        .ciram_addr (ciram_addr),
        .ciram_sel  (ciram_sel)
    );
endmodule

// File: tb/cart_mapper_test.sv
module cart_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [18:0] prg_rom_addr;
    logic [12:0] wram_addr;
    logic        wram_sel, wram_en, open_bus;
    logic [17:0] chr_addr;
    logic [10:0] ciram_addr;
    logic        ciram_sel;

    int checks = 0;
    int errors = 0;

    logic [7:0] chr_m [8];
    logic [7:0] prg_m [4];
    logic [1:0] mir_m;

    always #2.5 clk = ~clk;

    cart_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .wram_addr(wram_addr), .wram_sel(wram_sel), .wram_en(wram_en),
        .open_bus(open_bus), .chr_addr(chr_addr), .ciram_addr(ciram_addr),
        .ciram_sel(ciram_sel)
    );

    // {index, data}
    localparam logic [11:0] VEC [12] = '{
        {4'd0,  8'h5A}, {4'd1,  8'hC3}, {4'd5,  8'h01}, {4'd7,  8'hFF},
        {4'd8,  8'h12}, {4'd9,  8'h3F}, {4'd10, 8'h40}, {4'd11, 8'hC5},
        {4'd12, 8'h01}, {4'd12, 8'h02}, {4'd12, 8'h03}, {4'd12, 8'h00}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] sel, input logic [7:0] d);
        cpu_write(16'h8000, sel);
        cpu_write(16'hA000, d);
        if (sel[3:0] < 4'd8) chr_m[sel[2:0]] = d;
        else if (sel[3:0] < 4'd12) prg_m[sel[1:0]] = d;
        else if (sel[3:0] == 4'd12) mir_m = d[1:0];
    endtask

    task automatic probe_prg(input string req, input logic [15:0] a);
        logic [7:0] b;
        cpu_wr = 1'b0; cpu_addr = a;
        #1;
        if (a[15:13] < 3'd3) begin
            check(req, "open_bus low read", {31'd0, open_bus}, 32'd1);
            check(req, "wram_en low read", {31'd0, wram_en}, 32'd0);
        end else begin
            b = (a[15:13] == 3'd7) ? 8'h3F : prg_m[a[14:13] - 2'd3];
            if (b[6]) begin
                check(req, "wram_sel", {31'd0, wram_sel}, 32'd1);
                check(req, "wram_en", {31'd0, wram_en}, {31'd0, b[7]});
                check(req, "open_bus", {31'd0, open_bus}, {31'd0, !b[7]});
                check(req, "wram_addr", {19'd0, wram_addr}, {19'd0, a[12:0]});
            end else begin
                check(req, "prg_rom_addr", {13'd0, prg_rom_addr}, {13'd0, b[5:0], a[12:0]});
                check(req, "rom sel/en/open", {29'd0, wram_sel, wram_en, open_bus}, 32'd0);
            end
        end
    endtask

    task automatic probe_ppu(input string req, input logic [13:0] a);
        logic pg;
        ppu_addr = a;
        #1;
        check("R11", "ciram_sel", {31'd0, ciram_sel}, {31'd0, a[13]});
        if (!a[13]) begin
            check(req, "chr_addr", {14'd0, chr_addr}, {14'd0, chr_m[a[12:10]], a[9:0]});
        end else begin
            case (mir_m)
                2'd0: pg = a[10];
                2'd1: pg = a[11];
                2'd2: pg = 1'b0;
                default: pg = 1'b1;
            endcase
            check(req, "ciram_addr", {21'd0, ciram_addr}, {21'd0, pg, a[9:0]});
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) chr_m[i] = 8'h00;
        for (int i = 0; i < 4; i++) prg_m[i] = 8'h00;
        mir_m = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state visible through translation
        probe_prg("R1", 16'h8123);
        probe_prg("R1", 16'hD456);
        probe_ppu("R1", 14'h1FFF);
        probe_ppu("R1", 14'h2655);

        // vector table: program each register, probe its effect
        for (int i = 0; i < 12; i++) begin
            logic [3:0] idx;
            idx = VEC[i][11:8];
            reg_write({4'd0, idx}, VEC[i][7:0]);
            if (idx < 4'd8) begin
                probe_ppu("R3", {1'b0, idx[2:0], 10'h2A7});
            end else if (idx < 4'd12) begin
                probe_prg((idx >= 4'd10) ? "R7" : "R4", {3'(idx - 4'd5), 13'h1ABC});
            end else begin
                probe_ppu("R9", 14'h2013);
                probe_ppu("R9", 14'h2413);
                probe_ppu("R9", 14'h2813);
                probe_ppu("R9", 14'h2C13);
            end
        end

        // R5: top window fixed even after all banks loaded
        probe_prg("R5", 16'hE000);
        probe_prg("R5", 16'hFFFF);

        // R6: reads below 0x6000 float
        probe_prg("R6", 16'h4123);
        probe_prg("R6", 16'h5FFF);

        // R8: writes into 0x6000 window always reach RAM despite ROM bank
        @(negedge clk);
        cpu_addr = 16'h6010; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1;
        check("R8", "wram sel/en on low write", {30'd0, wram_sel, wram_en}, 32'd3);
        cpu_addr = 16'h9000;
        #1;
        check("R8", "wram_en on high write", {31'd0, wram_en}, 32'd0);
        cpu_addr = 16'h4000;
        #1;
        check("R8", "wram_en on io write", {31'd0, wram_en}, 32'd0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R2: only low nibble of index write used
        reg_write(8'hF3, 8'h9C);
        probe_ppu("R2", 14'h0D55);
        reg_write(8'hE9, 8'h2B);
        probe_prg("R2", 16'h8001);

        // R10: unused indices change nothing
        reg_write(8'd13, 8'hFF);
        reg_write(8'd14, 8'hAA);
        reg_write(8'd15, 8'h55);
        for (int s = 0; s < 8; s++) probe_ppu("R10", {1'b0, 3'(s), 10'h0F0});
        probe_prg("R10", 16'h6ABC);
        probe_prg("R10", 16'h8ABC);
        probe_prg("R10", 16'hA0BC);
        probe_prg("R10", 16'hCFFF);
        probe_ppu("R10", 14'h2C01);

        // R1: reset returns everything to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) chr_m[i] = 8'h00;
        for (int i = 0; i < 4; i++) prg_m[i] = 8'h00;
        mir_m = 2'd0;
        probe_prg("R1", 16'hA777);
        probe_ppu("R1", 14'h1C00);
        probe_ppu("R1", 14'h2BFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule